// File: doc/BRIEF.md
# ADC Scan Channel Sequencer

This block decides which analog input a 12-input converter front end converts next while it serves one read request. When a start strobe arrives it samples the scan configuration: a 2-bit scan mode, a 4-bit channel select, a flag that says whether the shared top input (channel 11) serves as a reference pin, and a flag that selects external-clock operation. It then issues channel numbers one at a time. Each channel comes with a one-cycle valid pulse. A last-of-scan flag marks the final channel.

The converter signals the end of each conversion with a done strobe, and the sequencer issues the next channel only after that strobe. Results come out in the same order as the channels, so a storage stage downstream can write them in the order it receives them. In external-clock operation the repeat modes never end by themselves. A not-acknowledge from the bus master, or a fresh start strobe, stops any running scan and returns the block to idle.

Top module: `scan_seq_top`

## Requirements
- R1: After synchronous active-low reset the block is idle: `ch_valid` and `ch_last` are 0, and no channel is issued until a start strobe arrives.
- R2: Mode `cfg_mode`=2'b00 issues channels 0, 1, ... up to the selected channel. A select value above 11 is treated as 11.
- R3: Mode 2'b01 with `cfg_ext_clk`=0 issues the selected channel eight times in a row. `ch_last` is set on the eighth issue.
- R4: Mode 2'b10 issues channels 6 up to the selected channel. A select of 6 or lower gives the single channel 6.
- R5: Mode 2'b11 with `cfg_ext_clk`=0 issues the selected channel once, with `ch_last` set.
- R6: With `cfg_ref_pin`=1, channel 11 is never part of a multichannel scan. Mode 2'b00 ends at min(select, 10). Mode 2'b10 ends at min(select, 10) and never below 6.
- R7: With `cfg_ext_clk`=1, modes 2'b01 and 2'b11 both issue the selected channel again after every done strobe. They never set `ch_last` and run until `nack`.
- R8: The first channel is valid in the cycle after the start strobe is sampled. Each later channel is valid in the cycle after a sampled `conv_done`. `ch_valid` is a single-cycle pulse. A `conv_done` sampled while idle or while `ch_valid` is high has no effect.
- R9: `ch_last` is high only together with the final channel's valid pulse. The `conv_done` that follows it returns the block to idle without issuing another channel.
- R10: A `nack` sampled during a scan, or a second `start` sampled during a scan, ends the scan: no further channel is issued. `nack` takes priority over `start` when the block is idle.
- R11: The configuration inputs are sampled only with the start strobe. Changing them during a scan does not change the channels issued.
- R12: In modes 2'b01 and 2'b11 a select value above 11 is treated as 11, and `cfg_ref_pin` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Scan mode: 00 up-from-0, 01 repeat, 10 upper range, 11 single |
| cfg_sel | input | 4 | Selected channel |
| cfg_ref_pin | input | 1 | 1: channel 11 pin serves as a reference |
| cfg_ext_clk | input | 1 | 1: external-clock operation |
| start | input | 1 | Read request strobe |
| conv_done | input | 1 | Conversion finished strobe |
| nack | input | 1 | Master not-acknowledge strobe |
| ch_out | output | 4 | Channel to convert |
| ch_valid | output | 1 | One-cycle pulse: `ch_out` is a new channel |
| ch_last | output | 1 | Final channel of the scan |

## Verification
The assertions check four properties on every cycle: the valid pulse lasts one cycle, the last flag never appears without a valid pulse, no channel follows a not-acknowledge or an idle cycle without start, and no issued channel is out of range or breaks the reference-pin exclusion. Only the bench scenarios can show that the exact channel order fits each mode and configuration. The same holds for the count of eight repeats, the clamping of large select values, the ignoring of done strobes and of configuration changes during a scan, and the abort on a second start.

// File: rtl/scan_seq_pkg.sv
// Shared types for the scan channel sequencer.
// Assumes a 2-bit mode field; the encodings below are decoded by scan_limits.
package scan_seq_pkg;

    typedef enum logic [1:0] {
        SCAN_UP     = 2'b00,  // channel 0 up to the selection
        SCAN_REPEAT = 2'b01,  // selected channel, fixed repeat count
        SCAN_UPPER  = 2'b10,  // upper base channel up to the selection
        SCAN_ONE    = 2'b11   // selected channel once
    } scan_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/scan_limits.sv
// scan_limits: turns the sampled configuration into a scan plan.
// The plan gives the first channel, the end channel, the repeats left after
// the first issue, a hold flag (same channel each time) and an endless flag.
// Assumes NUM_CH >= UPPER_BASE + 2 so that the reference cap stays at or above the base.
module scan_limits
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH     = 12,
    parameter int CH_W       = 4,
    parameter int UPPER_BASE = 6,
    parameter int REPEAT     = 8,
    parameter int RW         = $clog2(REPEAT + 1)
) (
    input  scan_mode_e       mode,
    input  logic [CH_W-1:0]  sel,
    input  logic             ref_pin,
    input  logic             ext_clk,
    output logic [CH_W-1:0]  first_ch,
    output logic [CH_W-1:0]  end_ch,
    output logic [RW-1:0]    reps,
    output logic             hold,
    output logic             endless
);
    localparam logic [CH_W-1:0] MAX_CH  = CH_W'(NUM_CH - 1);
    localparam logic [CH_W-1:0] REF_CAP = CH_W'(NUM_CH - 2);
    localparam logic [CH_W-1:0] BASE    = CH_W'(UPPER_BASE);

    logic [CH_W-1:0] sel_c;
    logic [CH_W-1:0] scan_top;

    // Clamp the selection to the physical channel range and the reference cap.
    always_comb begin
        sel_c    = (sel > MAX_CH) ? MAX_CH : sel;
        scan_top = (ref_pin && (sel_c > REF_CAP)) ? REF_CAP : sel_c;
    end

    // Decode the mode into start point, stop point and repeat rule.
    always_comb begin
        first_ch = '0;
        end_ch   = '0;
        reps     = '0;
        hold     = 1'b0;
        endless  = 1'b0;
        case (mode)
            SCAN_UP: begin
                first_ch = '0;
                end_ch   = scan_top;
            end
            SCAN_UPPER: begin
                first_ch = BASE;
                end_ch   = (scan_top < BASE) ? BASE : scan_top;
            end
            SCAN_REPEAT: begin
                first_ch = sel_c;
                end_ch   = sel_c;
                hold     = 1'b1;
                endless  = ext_clk;
                reps     = RW'(REPEAT - 1);
            end
            SCAN_ONE: begin
                first_ch = sel_c;
                end_ch   = sel_c;
                hold     = 1'b1;
                endless  = ext_clk;
            end
            default: begin
                first_ch = '0;
                end_ch   = '0;
            end
        endcase
    end

    // R2/R4: the plan must never run downwards.
    always_comb begin
        assert (first_ch <= end_ch) else $error("scan plan runs downwards (R2/R4)");
    end

endmodule

// File: rtl/scan_step.sv
// scan_step: computes the channel that follows the one just issued, the
// repeats left after it, and whether that next channel closes the scan.
// Assumes the caller only uses the result while a scan is running.
module scan_step #(
    parameter int CH_W = 4,
    parameter int RW   = 4
) (
    input  logic [CH_W-1:0] cur_ch,
    input  logic [CH_W-1:0] end_ch,
    input  logic [RW-1:0]   reps,
    input  logic            hold,
    input  logic            endless,
    output logic [CH_W-1:0] nxt_ch,
    output logic [RW-1:0]   nxt_reps,
    output logic            nxt_last
);
    // Advance the channel (or the repeat count) and judge the scan end.
    always_comb begin
        if (hold) begin
            nxt_ch   = cur_ch;
            nxt_reps = (reps == '0) ? '0 : reps - RW'(1);
            nxt_last = !endless && (nxt_reps == '0);
        end else begin
            nxt_ch   = cur_ch + CH_W'(1);
            nxt_reps = reps;
            nxt_last = !endless && (nxt_ch == end_ch);
        end
    end

endmodule

// File: rtl/scan_seq_top.sv
// scan_seq_top: issues the sequence of channels for one read request.
// Samples the configuration on start, issues one channel per conversion
// with a one-cycle valid pulse, and waits for conv_done between channels.
// nack, or start during a scan, aborts to idle. Assumes the strobes are
// synchronous to clk; reset is synchronous and active low.
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH     = 12,
    parameter int CH_W       = 4,
    parameter int UPPER_BASE = 6,
    parameter int REPEAT     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cfg_mode,
    input  logic [CH_W-1:0] cfg_sel,
    input  logic            cfg_ref_pin,
    input  logic            cfg_ext_clk,
    input  logic            start,
    input  logic            conv_done,
    input  logic            nack,
    output logic [CH_W-1:0] ch_out,
    output logic            ch_valid,
    output logic            ch_last
);
    localparam int              RW     = $clog2(REPEAT + 1);
    localparam logic [CH_W-1:0] MAX_CH = CH_W'(NUM_CH - 1);

    seq_state_e      state;
    logic [CH_W-1:0] end_q;
    logic [RW-1:0]   reps_q;
    logic            hold_q;
    logic            endless_q;
    logic            ref_q;
    logic            last_q;

    logic [CH_W-1:0] plan_first;
    logic [CH_W-1:0] plan_end;
    logic [RW-1:0]   plan_reps;
    logic            plan_hold;
    logic            plan_endless;
    logic            plan_first_last;

    logic [CH_W-1:0] nxt_ch;
    logic [RW-1:0]   nxt_reps;
    logic            nxt_last;

    scan_limits #(
        .NUM_CH     (NUM_CH),
        .CH_W       (CH_W),
        .UPPER_BASE (UPPER_BASE),
        .REPEAT     (REPEAT),
        .RW         (RW)
    ) u_limits (
        .mode     (scan_mode_e'(cfg_mode)),
        .sel      (cfg_sel),
        .ref_pin  (cfg_ref_pin),
        .ext_clk  (cfg_ext_clk),
        .first_ch (plan_first),
        .end_ch   (plan_end),
        .reps     (plan_reps),
        .hold     (plan_hold),
        .endless  (plan_endless)
    );

    scan_step #(
        .CH_W (CH_W),
        .RW   (RW)
    ) u_step (
        .cur_ch   (ch_out),
        .end_ch   (end_q),
        .reps     (reps_q),
        .hold     (hold_q),
        .endless  (endless_q),
        .nxt_ch   (nxt_ch),
        .nxt_reps (nxt_reps),
        .nxt_last (nxt_last)
    );

    // Whether the first channel of a new plan is already the final one.
    always_comb begin
        plan_first_last = !plan_endless &&
                          (plan_hold ? (plan_reps == '0) : (plan_first == plan_end));
    end

    // Sequencer: load the plan on start, step on conv_done, abort on nack/start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ch_out    <= '0;
            ch_valid  <= 1'b0;
            ch_last   <= 1'b0;
            end_q     <= '0;
            reps_q    <= '0;
            hold_q    <= 1'b0;
            endless_q <= 1'b0;
            ref_q     <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            ch_valid <= 1'b0;
            ch_last  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && !nack) begin
                        state     <= ST_WAIT;
                        ch_out    <= plan_first;
                        ch_valid  <= 1'b1;
                        ch_last   <= plan_first_last;
                        last_q    <= plan_first_last;
                        end_q     <= plan_end;
                        reps_q    <= plan_reps;
                        hold_q    <= plan_hold;
                        endless_q <= plan_endless;
                        ref_q     <= cfg_ref_pin;
                    end
                end
                ST_WAIT: begin
                    if (nack || start) begin
                        state <= ST_IDLE;
                    end else if (conv_done && !ch_valid) begin
                        if (last_q) begin
                            state <= ST_IDLE;
                        end else begin
                            ch_out   <= nxt_ch;
                            reps_q   <= nxt_reps;
                            ch_valid <= 1'b1;
                            ch_last  <= nxt_last;
                            last_q   <= nxt_last;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a valid pulse never lasts longer than one cycle.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |=> !ch_valid);

    // R8: an idle cycle without start issues nothing.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> !ch_valid);

    // R9: the last flag only appears with a valid channel.
    p_last_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_last |-> ch_valid);

    // R10: no channel follows a not-acknowledge.
    p_nack_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nack |=> !ch_valid);

    // R2: every issued channel exists.
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> (ch_out <= MAX_CH));

    // R6: a multichannel scan with the reference pin never issues channel 11.
    p_ref_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && ref_q && !hold_q) |-> (ch_out != MAX_CH));

    // R7: an endless scan never flags a last channel.
    p_endless_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && endless_q) |-> !ch_last);

endmodule

// File: tb/scan_seq_top_test.sv
// Bench for scan_seq_top: directed corner cases plus seeded random scans,
// checked against a channel list built from the requirements.
module scan_seq_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b11;
    logic [3:0] cfg_sel = 4'd0;
    logic       cfg_ref_pin = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic       start = 1'b0;
    logic       conv_done = 1'b0;
    logic       nack = 1'b0;
    logic [3:0] ch_out;
    logic       ch_valid;
    logic       ch_last;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    int exp_ch [0:15];
    int exp_n;
    bit exp_endless;

    always #2 clk = ~clk;

    scan_seq_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (cfg_mode),
        .cfg_sel     (cfg_sel),
        .cfg_ref_pin (cfg_ref_pin),
        .cfg_ext_clk (cfg_ext_clk),
        .start       (start),
        .conv_done   (conv_done),
        .nack        (nack),
        .ch_out      (ch_out),
        .ch_valid    (ch_valid),
        .ch_last     (ch_last)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done_flag) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL R8 watchdog expired actual=%0d expected=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected channel list from the requirement text.
    task automatic build_plan(input int m, input int s, input bit r, input bit e);
        int sc;
        int top;
        sc = (s > 11) ? 11 : s;
        top = (r && sc > 10) ? 10 : sc;
        exp_endless = 1'b0;
        exp_n = 0;
        case (m)
            0: begin
                for (int c = 0; c <= top; c++) begin exp_ch[exp_n] = c; exp_n++; end
            end
            2: begin
                if (top < 6) top = 6;
                for (int c = 6; c <= top; c++) begin exp_ch[exp_n] = c; exp_n++; end
            end
            1: begin
                exp_endless = e;
                exp_n = e ? 1 : 8;
                for (int k = 0; k < 8; k++) exp_ch[k] = sc;
            end
            default: begin
                exp_endless = e;
                exp_n = 1;
                exp_ch[0] = sc;
            end
        endcase
    endtask

    function automatic string req_tag(input int m, input int s, input bit r, input bit e);
        if ((m == 1 || m == 3) && e) return "R7";
        if ((m == 1 || m == 3) && s > 11) return "R12";
        if (m == 1) return "R3";
        if (m == 3) return "R5";
        if (r) return "R6";
        if (m == 2) return "R4";
        return "R2";
    endfunction

    task automatic pulse_done();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Run one whole scan; optionally scramble the configuration after start (R11).
    task automatic run_scan(input int m, input int s, input bit r, input bit e, input bit scramble);
        int total;
        string tag;
        build_plan(m, s, r, e);
        tag = req_tag(m, s, r, e);
        total = exp_endless ? 6 : exp_n;
        @(negedge clk);
        cfg_mode = 2'(m); cfg_sel = 4'(s); cfg_ref_pin = r; cfg_ext_clk = e;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            cfg_mode = 2'($urandom_range(0, 3));
            cfg_sel = 4'($urandom_range(0, 15));
            cfg_ref_pin = 1'($urandom_range(0, 1));
            cfg_ext_clk = 1'($urandom_range(0, 1));
        end
        for (int i = 0; i < total; i++) begin
            check_eq({tag, " R8 valid on issue"}, ch_valid, 1);
            check_eq({tag, scramble ? " R11 channel" : " channel"}, ch_out, exp_ch[exp_endless ? 0 : i]);
            check_eq({tag, " R9 last flag"}, ch_last, (!exp_endless && i == exp_n - 1) ? 1 : 0);
            @(negedge clk);
            check_eq("R8 single-cycle valid", ch_valid, 0);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            if (exp_endless && i == total - 1) begin
                nack = 1'b1;
                @(negedge clk);
                nack = 1'b0;
                check_eq("R10 nack ends endless scan", ch_valid, 0);
                @(negedge clk);
                pulse_done();
                check_eq("R10 no channel after nack", ch_valid, 0);
                return;
            end
            pulse_done();
        end
        check_eq("R9 idle after final done", ch_valid, 0);
        pulse_done();
        check_eq("R8 done while idle ignored", ch_valid, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check_eq("R1 valid low in reset", ch_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 valid low after reset", ch_valid, 0);
        check_eq("R1 last low after reset", ch_last, 0);
        pulse_done();
        check_eq("R1 done before start issues nothing", ch_valid, 0);

        // Directed scans
        run_scan(0, 5, 0, 0, 0);
        run_scan(0, 15, 0, 0, 0);
        run_scan(0, 15, 1, 0, 0);
        run_scan(0, 11, 1, 0, 0);
        run_scan(2, 3, 0, 0, 0);
        run_scan(2, 9, 0, 0, 0);
        run_scan(2, 11, 1, 0, 0);
        run_scan(2, 15, 1, 0, 0);
        run_scan(1, 4, 0, 0, 0);
        run_scan(3, 7, 0, 0, 0);
        run_scan(1, 9, 0, 1, 0);
        run_scan(3, 2, 1, 1, 0);
        run_scan(3, 14, 1, 0, 0);
        run_scan(1, 13, 1, 0, 0);
        run_scan(0, 0, 0, 0, 1);

        // R8: conv_done sampled while valid is high is ignored
        @(negedge clk);
        cfg_mode = 2'b00; cfg_sel = 4'd3; cfg_ref_pin = 1'b0; cfg_ext_clk = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R8 first channel", ch_out, 0);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check_eq("R8 early done ignored", ch_valid, 0);
        @(negedge clk);
        check_eq("R8 still waiting", ch_valid, 0);
        pulse_done();
        check_eq("R8 valid after real done", ch_valid, 1);
        check_eq("R8 second channel", ch_out, 1);
        nack = 1'b1;
        @(negedge clk);
        nack = 1'b0;
        pulse_done();
        check_eq("R10 nack mid scan", ch_valid, 0);

        // R10: second start in the middle of a scan aborts it
        cfg_mode = 2'b00; cfg_sel = 4'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R10 scan begins", ch_out, 0);
        @(negedge clk);
        pulse_done();
        check_eq("R10 channel 1 issued", ch_out, 1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R10 restart aborts", ch_valid, 0);
        pulse_done();
        check_eq("R10 no channel after abort", ch_valid, 0);

        // R10: nack beats start when idle
        nack = 1'b1; start = 1'b1;
        @(negedge clk);
        nack = 1'b0; start = 1'b0;
        check_eq("R10 nack priority over start", ch_valid, 0);
        pulse_done();
        check_eq("R10 stays idle", ch_valid, 0);

        // Seeded random scans
        for (int t = 0; t < 60; t++) begin
            run_scan($urandom_range(0, 3), $urandom_range(0, 15),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1);
        end

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule